// File: doc/BRIEF.md
# Coprocessor Task Trigger Dispatcher

The dispatcher sits between the trigger sources of a chip and the task engine of a math coprocessor. It decides which of eight tasks the engine runs next. Each task has a pending flag. The flag is set by a rising edge on that task's peripheral trigger line or by a host force write, and it is cancelled by a host clear write. A pending task is launched only when its enable bit is set. The dispatcher then raises a one-cycle start strobe with the task number and the task's programmable entry vector.

Foreground tasks run one at a time and to completion. When the engine reports a stop, the dispatcher raises a one-cycle completion pulse that carries the task number. In that same cycle it launches the next pending, enabled task. The highest task index is the background task. It is launched only when no foreground task is waiting. While it runs, any waiting foreground task preempts it, unless the background code holds its critical-section lock. On preemption the engine's current program counter is saved. When the foreground work ends, the background task resumes from that saved vector.

A host soft reset aborts all running work and clears the enable register. The hard reset returns every register to zero.

Top module: `tdx_dispatcher`

## Requirements
- R1: Writing `vec_data` with `vec_we` high stores it as the entry vector of task `vec_idx`. A fresh launch of task k presents that vector on `start_vec_o`.
- R2: A trigger line sets its pending flag only on a low-to-high change, which the dispatcher sees as a sample high after a sample low. A line held high through reset, or held high after a launch, sets nothing.
- R3: A force write sets the pending flag of every task whose bit is 1 in `force_mask` (bit k is task k, so 0x3 marks tasks 0 and 1). The write is ignored unless the force-enable control bit is 1. That bit is written with `ctl_we` and is 0 after reset.
- R4: A pending task whose enable bit (bit k of the register written by `en_we`) is 0 stays pending and is not launched. Setting that bit launches it one cycle later.
- R5: A clear write removes the pending flags selected by `clear_mask`. If a trigger edge or force for the same task arrives in the same cycle, the task ends up pending.
- R6: Among the tasks that are pending and enabled, the lowest index wins. The pending flag is visible one cycle after its trigger. `start_o` rises one cycle after that, and in that same cycle the launched task's pending flag clears.
- R7: In the cycle where `done_irq_o` reports a stop, the next pending, enabled task is already started, with no host action.
- R8: While a foreground task (index below 7) runs, no other task starts until it stops.
- R9: Task 7 is the background task. It is started only when no foreground task is pending and enabled. While it runs without `bg_lock_i`, a pending, enabled foreground task preempts it and `eng_pc_i` is saved. After the foreground work ends, the dispatcher restarts task 7 with the saved value on `start_vec_o`. While it runs with `bg_lock_i` high, no preemption occurs. A suspended background task keeps its running flag.
- R10: A stop while a task is active gives a one-cycle `done_irq_o`, one cycle later, with that task in `done_task_o`. The running flag clears in the same cycle. A stop while idle gives nothing.
- R11: A soft reset leaves nothing running, gives no completion pulse and clears all enable bits. Pending flags are kept.
- R12: `run_o` has one bit per running task, `busy_o` is high when any bit is set, and `pend_o` shows the pending flags. After the hard reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| trig_i | input | 8 | Per-task peripheral trigger lines |
| ctl_we | input | 1 | Control write strobe |
| ctl_force_en | input | 1 | Force-enable value for a control write |
| force_we | input | 1 | Force write strobe |
| force_mask | input | 8 | Tasks to mark pending |
| clear_we | input | 1 | Clear write strobe |
| clear_mask | input | 8 | Tasks whose pending flag is cancelled |
| en_we | input | 1 | Enable register write strobe |
| en_data | input | 8 | New enable register value |
| vec_we | input | 1 | Vector write strobe |
| vec_idx | input | 3 | Task whose vector is written |
| vec_data | input | 16 | Entry vector value |
| soft_rst_i | input | 1 | Host soft reset pulse |
| stop_i | input | 1 | Stop report from the task engine |
| bg_lock_i | input | 1 | Background critical-section lock |
| eng_pc_i | input | 16 | Engine program counter, saved on preemption |
| start_o | output | 1 | One-cycle start strobe |
| start_task_o | output | 3 | Task being started |
| start_vec_o | output | 16 | Entry or resume vector |
| run_o | output | 8 | Per-task running flags |
| busy_o | output | 1 | Any task running |
| pend_o | output | 8 | Pending flags |
| done_irq_o | output | 1 | One-cycle completion pulse |
| done_task_o | output | 3 | Task that completed |

## Verification
The assertions take for granted that `stop_i` is a one-cycle report that refers to the task the engine is currently executing. They also assume that `eng_pc_i` holds the background program counter in the cycle a preemption happens, and that `bg_lock_i` is raised only while the background code runs. The bench drives every host write and every stop as a single-cycle strobe. It raises stop only after a start has been observed, and it changes the lock and the program counter only while the background task is running.

// File: rtl/tdx_pkg.sv
package tdx_pkg;

    localparam int TDX_MAX_TASKS = 32;
    localparam int TDX_IDX_W     = 5;

    typedef enum logic [1:0] {
        LK_NONE,
        LK_FG,
        LK_BG,
        LK_RESUME
    } launch_kind_e;

    function automatic logic [TDX_IDX_W-1:0] tdx_lowest(input logic [TDX_MAX_TASKS-1:0] v);
        logic [TDX_IDX_W-1:0] r;
        r = '0;
        for (int i = TDX_MAX_TASKS - 1; i >= 0; i--) begin
            if (v[i]) r = TDX_IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/tdx_pend.sv
module tdx_pend #(
    parameter int NUM_TASKS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 srst,
    input  logic [NUM_TASKS-1:0] trig_i,
    input  logic                 ctl_we,
    input  logic                 ctl_force_en,
    input  logic                 force_we,
    input  logic [NUM_TASKS-1:0] force_mask,
    input  logic                 clear_we,
    input  logic [NUM_TASKS-1:0] clear_mask,
    input  logic                 en_we,
    input  logic [NUM_TASKS-1:0] en_data,
    input  logic [NUM_TASKS-1:0] launch_clr,
    output logic [NUM_TASKS-1:0] pend_q,
    output logic [NUM_TASKS-1:0] en_q
);

    logic force_en_q;
    logic [NUM_TASKS-1:0] force_set;
    logic [NUM_TASKS-1:0] clr_set;

    assign force_set = (force_we && force_en_q) ? force_mask : '0;
    assign clr_set   = clear_we ? clear_mask : '0;

    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_cell
        logic line_q;
        logic flag_q;
        logic rise;

        assign rise = trig_i[g] && !line_q;

        always_ff @(posedge clk) begin
            line_q <= trig_i[g];
            if (rst) begin
                flag_q <= 1'b0;
            end else begin
                flag_q <= (flag_q && !clr_set[g] && !launch_clr[g]) || rise || force_set[g];
            end
        end

        assign pend_q[g] = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= '0;
            force_en_q <= 1'b0;
        end else begin
            if (srst)       en_q <= '0;
            else if (en_we) en_q <= en_data;
            if (ctl_we)     force_en_q <= ctl_force_en;
        end
    end

    AST_LAUNCH_NEEDS_CAND: assert property (@(posedge clk) disable iff (rst)
        (launch_clr != '0) |-> ((launch_clr & ~(pend_q & en_q)) == '0)); // R4
    AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(launch_clr)); // R6
    AST_SRST_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
        srst |=> (en_q == '0)); // R11

endmodule

// File: rtl/tdx_vecs.sv
module tdx_vecs #(
    parameter int NUM_TASKS = 8,
    parameter int VEC_W     = 16,
    localparam int TW       = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vec_we,
    input  logic [TW-1:0]    vec_idx,
    input  logic [VEC_W-1:0] vec_data,
    input  logic [TW-1:0]    rd_idx,
    output logic [VEC_W-1:0] rd_data
);

    logic [VEC_W-1:0] table_q [NUM_TASKS];

    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_vec
        logic [VEC_W-1:0] v_q;
        always_ff @(posedge clk) begin
            if (rst)                                 v_q <= '0;
            else if (vec_we && vec_idx == TW'(g))    v_q <= vec_data;
        end
        assign table_q[g] = v_q;
    end

    assign rd_data = table_q[rd_idx];

endmodule

// File: rtl/tdx_sched.sv
module tdx_sched
    import tdx_pkg::*;
#(
    parameter int NUM_TASKS = 8,
    parameter int VEC_W     = 16,
    parameter int BG_TASK   = NUM_TASKS - 1,
    localparam int TW       = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 srst,
    input  logic [NUM_TASKS-1:0] cand,
    input  logic                 stop_i,
    input  logic                 bg_lock_i,
    input  logic [VEC_W-1:0]     eng_pc,
    input  logic [VEC_W-1:0]     rd_vec,
    output logic [TW-1:0]        rd_idx,
    output logic [NUM_TASKS-1:0] launch_clr,
    output logic                 start_o,
    output logic [TW-1:0]        start_task_o,
    output logic [VEC_W-1:0]     start_vec_o,
    output logic [NUM_TASKS-1:0] run_o,
    output logic                 done_irq_o,
    output logic [TW-1:0]        done_task_o
);

    typedef struct packed {
        logic          fg_act;
        logic [TW-1:0] fg_id;
        logic          bg_act;
        logic          bg_susp;
    } sched_state_t;

    localparam logic [NUM_TASKS-1:0] BG_MASK = NUM_TASKS'(1) << BG_TASK;

    sched_state_t st, nx;
    logic [VEC_W-1:0] ret_q;
    launch_kind_e kind;
    logic [NUM_TASKS-1:0] fg_cand;
    logic [TW-1:0] pick;
    logic any_fg, stop_hit, fg_free, bg_stops, bg_live, bg_runnable;

    assign fg_cand     = cand & ~BG_MASK;
    assign any_fg      = |fg_cand;
    assign pick        = TW'(tdx_lowest(TDX_MAX_TASKS'(fg_cand)));
    assign rd_idx      = any_fg ? pick : TW'(BG_TASK);
    assign stop_hit    = stop_i && (st.fg_act || st.bg_act);
    assign fg_free     = !st.fg_act || stop_i;
    assign bg_stops    = stop_i && !st.fg_act && st.bg_act;
    assign bg_live     = st.bg_act && !bg_stops;
    assign bg_runnable = bg_live && !st.bg_susp;

    always_comb begin
        kind = LK_NONE;
        if (srst) begin
            kind = LK_NONE;
        end else if (fg_free && any_fg && !(bg_runnable && bg_lock_i)) begin
            kind = LK_FG;
        end else if (fg_free && st.bg_susp) begin
            kind = LK_RESUME;
        end else if (fg_free && !bg_live && cand[BG_TASK]) begin
            kind = LK_BG;
        end
    end

    always_comb begin
        nx = st;
        launch_clr = '0;
        if (srst) begin
            nx = '0;
        end else begin
            if (stop_hit) begin
                if (st.fg_act) nx.fg_act = 1'b0;
                else           nx.bg_act = 1'b0;
            end
            case (kind)
                LK_FG: begin
                    nx.fg_act  = 1'b1;
                    nx.fg_id   = pick;
                    if (bg_runnable) nx.bg_susp = 1'b1;
                    launch_clr = NUM_TASKS'(1) << pick;
                end
                LK_RESUME: nx.bg_susp = 1'b0;
                LK_BG: begin
                    nx.bg_act  = 1'b1;
                    nx.bg_susp = 1'b0;
                    launch_clr = BG_MASK;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= '0;
            ret_q        <= '0;
            start_o      <= 1'b0;
            start_task_o <= '0;
            start_vec_o  <= '0;
            done_irq_o   <= 1'b0;
            done_task_o  <= '0;
        end else begin
            st         <= nx;
            start_o    <= (kind != LK_NONE);
            done_irq_o <= stop_hit && !srst;
            if (stop_hit) done_task_o <= st.fg_act ? st.fg_id : TW'(BG_TASK);
            if (kind == LK_FG && bg_runnable) ret_q <= eng_pc;
            case (kind)
                LK_FG: begin
                    start_task_o <= pick;
                    start_vec_o  <= rd_vec;
                end
                LK_BG: begin
                    start_task_o <= TW'(BG_TASK);
                    start_vec_o  <= rd_vec;
                end
                LK_RESUME: begin
                    start_task_o <= TW'(BG_TASK);
                    start_vec_o  <= ret_q;
                end
                default: ;
            endcase
        end
    end

    assign run_o = (st.fg_act ? (NUM_TASKS'(1) << st.fg_id) : '0) | (st.bg_act ? BG_MASK : '0);

    AST_FG_HELD: assert property (@(posedge clk) disable iff (rst)
        (st.fg_act && !stop_i && !srst) |=> (st.fg_act && st.fg_id == $past(st.fg_id))); // R8
    AST_LOCK_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (st.bg_act && !st.bg_susp && bg_lock_i && !stop_i && !srst) |=> !st.bg_susp); // R9
    AST_SUSP_UNDER_FG: assert property (@(posedge clk) disable iff (rst)
        st.bg_susp |-> (st.fg_act && st.bg_act)); // R9
    AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
        done_irq_o |-> $past(stop_i)); // R10
    AST_SRST_IDLE: assert property (@(posedge clk) disable iff (rst)
        srst |=> (run_o == '0 && !done_irq_o)); // R11

endmodule

// File: rtl/tdx_dispatcher.sv
module tdx_dispatcher #(
    parameter int NUM_TASKS = 8,
    parameter int VEC_W     = 16,
    parameter int BG_TASK   = NUM_TASKS - 1,
    localparam int TW       = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_TASKS-1:0] trig_i,
    input  logic                 ctl_we,
    input  logic                 ctl_force_en,
    input  logic                 force_we,
    input  logic [NUM_TASKS-1:0] force_mask,
    input  logic                 clear_we,
    input  logic [NUM_TASKS-1:0] clear_mask,
    input  logic                 en_we,
    input  logic [NUM_TASKS-1:0] en_data,
    input  logic                 vec_we,
    input  logic [TW-1:0]        vec_idx,
    input  logic [VEC_W-1:0]     vec_data,
    input  logic                 soft_rst_i,
    input  logic                 stop_i,
    input  logic                 bg_lock_i,
    input  logic [VEC_W-1:0]     eng_pc_i,
    output logic                 start_o,
    output logic [TW-1:0]        start_task_o,
    output logic [VEC_W-1:0]     start_vec_o,
    output logic [NUM_TASKS-1:0] run_o,
    output logic                 busy_o,
    output logic [NUM_TASKS-1:0] pend_o,
    output logic                 done_irq_o,
    output logic [TW-1:0]        done_task_o
);

    logic [NUM_TASKS-1:0] pend_q, en_q, launch_clr;
    logic [TW-1:0]        rd_idx;
    logic [VEC_W-1:0]     rd_vec;

    tdx_pend #(.NUM_TASKS(NUM_TASKS)) i_pend (
        .clk(clk), .rst(rst), .srst(soft_rst_i), .trig_i(trig_i),
        .ctl_we(ctl_we), .ctl_force_en(ctl_force_en),
        .force_we(force_we), .force_mask(force_mask),
        .clear_we(clear_we), .clear_mask(clear_mask),
        .en_we(en_we), .en_data(en_data), .launch_clr(launch_clr),
        .pend_q(pend_q), .en_q(en_q)
    );

    tdx_vecs #(.NUM_TASKS(NUM_TASKS), .VEC_W(VEC_W)) i_vecs (
        .clk(clk), .rst(rst), .vec_we(vec_we), .vec_idx(vec_idx),
        .vec_data(vec_data), .rd_idx(rd_idx), .rd_data(rd_vec)
    );

    tdx_sched #(.NUM_TASKS(NUM_TASKS), .VEC_W(VEC_W), .BG_TASK(BG_TASK)) i_sched (
        .clk(clk), .rst(rst), .srst(soft_rst_i), .cand(pend_q & en_q),
        .stop_i(stop_i), .bg_lock_i(bg_lock_i), .eng_pc(eng_pc_i), .rd_vec(rd_vec),
        .rd_idx(rd_idx), .launch_clr(launch_clr), .start_o(start_o),
        .start_task_o(start_task_o), .start_vec_o(start_vec_o), .run_o(run_o),
        .done_irq_o(done_irq_o), .done_task_o(done_task_o)
    );

    assign busy_o = |run_o;
    assign pend_o = pend_q;

    AST_BUSY_MATCHES_RUN: assert property (@(posedge clk) disable iff (rst)
        busy_o == (run_o != '0)); // R12
    AST_ONE_FOREGROUND: assert property (@(posedge clk) disable iff (rst)
        $countones(run_o & ~(NUM_TASKS'(1) << BG_TASK)) <= 1); // R8

endmodule

// File: tb/test_tdx_dispatcher.sv
module test_tdx_dispatcher;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] trig_i = '0;
    logic ctl_we = 0, ctl_force_en = 0, force_we = 0, clear_we = 0, en_we = 0, vec_we = 0;
    logic [7:0] force_mask = '0, clear_mask = '0, en_data = '0;
    logic [2:0] vec_idx = '0;
    logic [15:0] vec_data = '0, eng_pc_i = '0;
    logic soft_rst_i = 0, stop_i = 0, bg_lock_i = 0;
    logic start_o, busy_o, done_irq_o;
    logic [2:0] start_task_o, done_task_o;
    logic [15:0] start_vec_o;
    logic [7:0] run_o, pend_o;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tdx_dispatcher i_tdx_dispatcher (
        .clk(clk), .rst(rst), .trig_i(trig_i), .ctl_we(ctl_we), .ctl_force_en(ctl_force_en),
        .force_we(force_we), .force_mask(force_mask), .clear_we(clear_we), .clear_mask(clear_mask),
        .en_we(en_we), .en_data(en_data), .vec_we(vec_we), .vec_idx(vec_idx), .vec_data(vec_data),
        .soft_rst_i(soft_rst_i), .stop_i(stop_i), .bg_lock_i(bg_lock_i), .eng_pc_i(eng_pc_i),
        .start_o(start_o), .start_task_o(start_task_o), .start_vec_o(start_vec_o), .run_o(run_o),
        .busy_o(busy_o), .pend_o(pend_o), .done_irq_o(done_irq_o), .done_task_o(done_task_o)
    );

    function automatic logic [15:0] vexp(input int k);
        return 16'h4000 | 16'(k << 4) | 16'(k);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic do_force(input logic [7:0] m);
        force_we = 1; force_mask = m; tick; force_we = 0;
    endtask

    task automatic do_stop;
        stop_i = 1; tick; stop_i = 0;
    endtask

    task automatic set_en(input logic [7:0] v);
        en_we = 1; en_data = v; tick; en_we = 0;
    endtask

    task automatic t_reset;
        trig_i[5] = 1;
        rst = 1; tick; tick; tick; rst = 0; tick;
        check("R12 start after reset", start_o, 0);
        check("R12 run after reset", run_o, 0);
        check("R12 busy after reset", busy_o, 0);
        check("R12 pend after reset", pend_o, 0);
        check("R12 done after reset", done_irq_o, 0);
        for (int k = 0; k < 8; k++) begin
            vec_we = 1; vec_idx = 3'(k); vec_data = vexp(k); tick;
        end
        vec_we = 0;
        set_en(8'hFF);
        tick; tick;
        check("R2 level high through reset no pend", pend_o, 0);
        check("R2 level high through reset no start", busy_o, 0);
    endtask

    task automatic t_edge;
        trig_i[2] = 1; tick;
        check("R6 pend visible", pend_o, 8'h04);
        check("R6 no start yet", start_o, 0);
        tick;
        check("R6 start strobe", start_o, 1);
        check("R6 start task", start_task_o, 2);
        check("R1 start vector", start_vec_o, vexp(2));
        check("R6 pend cleared on start", pend_o, 0);
        check("R12 run flag", run_o, 8'h04);
        check("R12 busy", busy_o, 1);
        tick;
        check("R6 strobe one cycle", start_o, 0);
        tick; tick;
        check("R2 held high no retrigger", pend_o, 0);
        do_stop;
        check("R10 done pulse", done_irq_o, 1);
        check("R10 done task", done_task_o, 2);
        check("R10 run cleared", run_o, 0);
        check("R2 no relaunch", start_o, 0);
        tick;
        check("R10 pulse one cycle", done_irq_o, 0);
        do_stop;
        check("R10 stop while idle ignored", done_irq_o, 0);
        trig_i = '0; tick;
    endtask

    task automatic t_force;
        do_force(8'h03);
        check("R3 force ignored when disabled", pend_o, 0);
        tick;
        check("R3 no start when disabled", start_o, 0);
        ctl_we = 1; ctl_force_en = 1; tick; ctl_we = 0;
        do_force(8'h03);
        check("R3 multi-bit force", pend_o, 8'h03);
        tick;
        check("R6 lowest first", start_task_o, 0);
        check("R6 start", start_o, 1);
        check("R6 remaining pend", pend_o, 8'h02);
        do_stop;
        check("R7 done task 0", done_task_o, 0);
        check("R7 chained start", start_o, 1);
        check("R7 chained task", start_task_o, 1);
        check("R1 chained vector", start_vec_o, vexp(1));
        do_stop;
        check("R10 done task 1", done_task_o, 1);
        check("R7 nothing left", busy_o, 0);
    endtask

    task automatic t_enable;
        set_en(8'hEF);
        do_force(8'h10);
        tick; tick; tick;
        check("R4 disabled stays pending", pend_o, 8'h10);
        check("R4 disabled not run", busy_o, 0);
        set_en(8'hFF);
        check("R4 not yet started", start_o, 0);
        tick;
        check("R4 starts after enable", start_o, 1);
        check("R4 task", start_task_o, 4);
        do_stop;
    endtask

    task automatic t_clear;
        set_en(8'hF7);
        do_force(8'h08);
        check("R5 pending before clear", pend_o, 8'h08);
        clear_we = 1; clear_mask = 8'h08; tick; clear_we = 0;
        check("R5 cleared", pend_o, 0);
        force_we = 1; force_mask = 8'h08; clear_we = 1; clear_mask = 8'h08; tick;
        force_we = 0; clear_we = 0;
        check("R5 set wins over clear", pend_o, 8'h08);
        clear_we = 1; tick; clear_we = 0;
        set_en(8'hFF);
        tick;
        check("R5 cleared task never starts", busy_o, 0);
    endtask

    task automatic t_nopreempt;
        do_force(8'h20); tick;
        check("R8 task 5 started", start_task_o, 5);
        do_force(8'h01);
        tick; tick;
        check("R8 no preempt start", start_o, 0);
        check("R8 run unchanged", run_o, 8'h20);
        check("R8 waiting pend", pend_o, 8'h01);
        do_stop;
        check("R8 chain after stop", start_task_o, 0);
        check("R7 chain strobe", start_o, 1);
        do_stop;
    endtask

    task automatic t_background;
        eng_pc_i = 16'hABCD;
        do_force(8'h80); tick;
        check("R9 bg start", start_task_o, 7);
        check("R9 bg vector", start_vec_o, vexp(7));
        check("R9 bg run", run_o, 8'h80);
        do_force(8'h04); tick;
        check("R9 preempt start", start_o, 1);
        check("R9 preempt task", start_task_o, 2);
        check("R9 both running flags", run_o, 8'h84);
        do_stop;
        check("R9 fg done", done_task_o, 2);
        check("R9 resume start", start_o, 1);
        check("R9 resume task", start_task_o, 7);
        check("R9 resume vector", start_vec_o, 16'hABCD);
        bg_lock_i = 1;
        do_force(8'h02);
        tick; tick; tick;
        check("R9 lock blocks preempt", start_o, 0);
        check("R9 lock run", run_o, 8'h80);
        check("R9 lock pend", pend_o, 8'h02);
        eng_pc_i = 16'h1234;
        bg_lock_i = 0; tick;
        check("R9 preempt after unlock", start_task_o, 1);
        check("R9 preempt after unlock run", run_o, 8'h82);
        do_stop;
        check("R9 second resume vector", start_vec_o, 16'h1234);
        do_stop;
        check("R10 bg done task", done_task_o, 7);
        check("R9 bg finished", busy_o, 0);
    endtask

    task automatic t_soft_reset;
        do_force(8'h08); tick;
        check("R11 task 3 running", run_o, 8'h08);
        soft_rst_i = 1; tick; soft_rst_i = 0;
        check("R11 run cleared", run_o, 0);
        check("R11 busy cleared", busy_o, 0);
        check("R11 no done pulse", done_irq_o, 0);
        do_force(8'h08); tick; tick;
        check("R11 enables cleared no start", busy_o, 0);
        check("R11 pend kept", pend_o, 8'h08);
        set_en(8'hFF); tick;
        check("R11 starts after re-enable", start_task_o, 3);
        rst = 1; tick; tick; rst = 0; tick;
        check("R12 hard reset pend", pend_o, 0);
        check("R12 hard reset run", run_o, 0);
        check("R12 hard reset start", start_o, 0);
        do_force(8'h01);
        check("R3 force enable reset", pend_o, 0);
    endtask

    initial begin
        tick;
        t_reset;
        t_edge;
        t_force;
        t_enable;
        t_clear;
        t_nopreempt;
        t_background;
        t_soft_reset;
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule